// File: doc/BRIEF.md
# Interrupt to Pin Routing Mapper

This block sits between the interrupt conditioning logic and the processors of a multi-processor cluster. It takes a vector of already masked, pending shared interrupt sources and steers each source to a pin on one or more processors. A source can go to a normal interrupt pin selected by a 6-bit index (64 pins per processor), to the processor's non-maskable interrupt line, or to both. For each processor, each pin output is the OR of every pending source routed to that pin on that processor. Outputs are registered.

Software sets up the routing through a 32-bit register bus. Every source has two words. The first is a routing word holding two delivery enables and the pin index. The second is a target word holding one select bit per processor. Routing words sit at a 4-byte stride from offset 0x000. Target words sit at a 4-byte stride from offset 0x100. Read data comes back one cycle after the read request.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, every routing word and target word is 0, every pin output and NMI output is 0, and the read data is 0.
- R2: The routing word for source i is at byte address 4*i. Writes keep bit 31 (pin enable), bit 30 (NMI enable) and bits 5:0 (pin index). A read returns those bits, and every other bit reads as 0.
- R3: The target word for source i is at byte address 0x100 + 4*i. Bit c selects processor c; only bits NUM_CPU-1:0 are stored, and the rest read as 0.
- R4: Read data appears on the read port in the cycle after the read request. Reading an address with no register behind it returns 0. A write to such an address changes no register.
- R5: A pending source whose routing word has bit 31 set drives pin `pin_o[c*64 + index]` high for every processor c selected in its target word. The output follows the pending input one clock later.
- R6: A pin output is the OR of all pending sources that select that pin index and that processor.
- R7: A pending source whose routing word has bit 30 set drives `nmi_o[c]` for each selected processor c. When bits 31 and 30 are both set, the source drives both the pin and the NMI line.
- R8: A source whose routing word has bits 31 and 30 both clear drives no output, even while it is pending.
- R9: A target word of 0 delivers the source nowhere. A target word with several bits set delivers the source to each selected processor.
- R10: A routing or target write changes the outputs from the second clock edge after the write request, not at the edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pend_i | input | NUM_SRC | Masked pending shared interrupt sources |
| pin_o | output | NUM_CPU*64 | Pin outputs, processor c at bits c*64 +: 64 |
| nmi_o | output | NUM_CPU | Non-maskable interrupt output per processor |

## Verification
A corrupted routing or target word shows up at the ports in two ways. It appears on the read port one cycle after the word is read. It also shows as a pin or NMI output that is set or clear when it should not be, one clock after the source becomes pending. A wrong index bit moves the output to a neighbouring pin, or to another processor's slice. Stepping each source through pin-only, NMI-only, both and neither settings separates those faults. Several sources are mapped to one pin to expose a broken OR, and the outputs are sampled at the edge that stores a write to catch wrong latency.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned PIN_IDX_W   = 6;
    localparam int unsigned PINS_PER_CPU = 1 << PIN_IDX_W;
    localparam int unsigned PIN_EN_BIT  = 31;
    localparam int unsigned NMI_EN_BIT  = 30;
    localparam int unsigned REGION_BIT  = 8;

    typedef struct packed {
        logic                 pin_en;
        logic                 nmi_en;
        logic [PIN_IDX_W-1:0] idx;
    } route_t;

    function automatic route_t word_to_route(input logic [WORD_W-1:0] w);
        route_t r;
        r.pin_en = w[PIN_EN_BIT];
        r.nmi_en = w[NMI_EN_BIT];
        r.idx    = w[PIN_IDX_W-1:0];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] route_to_word(input route_t r);
        logic [WORD_W-1:0] w;
        w                  = '0;
        w[PIN_EN_BIT]      = r.pin_en;
        w[NMI_EN_BIT]      = r.nmi_en;
        w[PIN_IDX_W-1:0]   = r.idx;
        return w;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 10
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              bus_valid_i,
    input  logic                              bus_write_i,
    input  logic [ADDR_W-1:0]                 bus_addr_i,
    input  logic [WORD_W-1:0]                 bus_wdata_i,
    output logic [WORD_W-1:0]                 bus_rdata_o,
    output route_t [NUM_SRC-1:0]              route_o,
    output logic   [NUM_SRC-1:0][NUM_CPU-1:0] tgt_o
);

    localparam int unsigned SLOT_W = REGION_BIT - 2;

    typedef struct packed {
        route_t [NUM_SRC-1:0]              route;
        logic   [NUM_SRC-1:0][NUM_CPU-1:0] tgt;
        logic   [WORD_W-1:0]               rdata;
    } regs_t;

    regs_t state_d, state_q;

    logic              addr_ok;
    logic              region_tgt;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot       = bus_addr_i[REGION_BIT-1:2];
        region_tgt = bus_addr_i[REGION_BIT];
        addr_ok    = (bus_addr_i[1:0] == 2'b00);
        if (ADDR_W > REGION_BIT + 1) begin
            addr_ok = addr_ok && (bus_addr_i >> (REGION_BIT + 1)) == '0;
        end
    end

    always_comb begin
        state_d = state_q;
        if (bus_valid_i && !bus_write_i) begin
            state_d.rdata = '0;
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (bus_valid_i && addr_ok && slot == SLOT_W'(s)) begin
                if (bus_write_i) begin
                    if (region_tgt) begin
                        state_d.tgt[s] = bus_wdata_i[NUM_CPU-1:0];
                    end else begin
                        state_d.route[s] = word_to_route(bus_wdata_i);
                    end
                end else begin
                    if (region_tgt) begin
                        state_d.rdata = WORD_W'(state_q.tgt[s]);
                    end else begin
                        state_d.rdata = route_to_word(state_q.route[s]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata_o = state_q.rdata;
    assign route_o     = state_q.route;
    assign tgt_o       = state_q.tgt;

    AST_RDATA_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[29:8] == '0); // R2

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        AST_ROUTE_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_valid_i && bus_write_i && addr_ok && !region_tgt && slot == SLOT_W'(s))
            |=> (route_to_word(route_o[s]) == ($past(bus_wdata_i) & 32'hC000_003F))); // R2
        AST_TGT_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_valid_i && bus_write_i && addr_ok && region_tgt && slot == SLOT_W'(s))
            |=> (tgt_o[s] == $past(bus_wdata_i[NUM_CPU-1:0]))); // R3
    end

endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_CPU = 4
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic   [NUM_SRC-1:0]                   pend_i,
    input  route_t [NUM_SRC-1:0]                   route_i,
    input  logic   [NUM_SRC-1:0][NUM_CPU-1:0]      tgt_i,
    output logic   [NUM_CPU*PINS_PER_CPU-1:0]      pin_o,
    output logic   [NUM_CPU-1:0]                   nmi_o
);

    typedef struct packed {
        logic [NUM_CPU-1:0][PINS_PER_CPU-1:0] pin;
        logic [NUM_CPU-1:0]                   nmi;
    } outs_t;

    outs_t out_d, out_q;

    always_comb begin
        out_d = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (pend_i[s] && tgt_i[s][c]) begin
                    if (route_i[s].pin_en) begin
                        out_d.pin[c][route_i[s].idx] = 1'b1;
                    end
                    if (route_i[s].nmi_en) begin
                        out_d.nmi[c] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pin_o = out_q.pin;
    assign nmi_o = out_q.nmi;

    logic any_enable;
    always_comb begin
        any_enable = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            any_enable = any_enable | route_i[s].pin_en | route_i[s].nmi_en;
        end
    end

    AST_PIN_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pin_o) |-> $past(|pend_i)); // R5
    AST_NMI_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|nmi_o) |-> $past(|pend_i)); // R7
    AST_QUIET_UNROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!any_enable) |-> (pin_o == '0 && nmi_o == '0)); // R8

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 10
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               bus_valid_i,
    input  logic                               bus_write_i,
    input  logic [ADDR_W-1:0]                  bus_addr_i,
    input  logic [31:0]                        bus_wdata_i,
    output logic [31:0]                        bus_rdata_o,
    input  logic [NUM_SRC-1:0]                 pend_i,
    output logic [NUM_CPU*PINS_PER_CPU-1:0]    pin_o,
    output logic [NUM_CPU-1:0]                 nmi_o
);

    route_t [NUM_SRC-1:0]              route_w;
    logic   [NUM_SRC-1:0][NUM_CPU-1:0] tgt_w;

    irq_route_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_valid_i (bus_valid_i),
        .bus_write_i (bus_write_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .route_o     (route_w),
        .tgt_o       (tgt_w)
    );

    irq_route_fabric #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU)
    ) u_fabric (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend_i),
        .route_i (route_w),
        .tgt_i   (tgt_w),
        .pin_o   (pin_o),
        .nmi_o   (nmi_o)
    );

endmodule

// File: tb/tb_irq_pin_router.sv
module tb_irq_pin_router;

    localparam int NS = 8;
    localparam int NC = 4;
    localparam int AW = 10;
    localparam int OW = NC * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NS-1:0] pend = '0;
    logic [OW-1:0] pin;
    logic [NC-1:0] nmi;

    always #10 clk = ~clk;

    irq_pin_router #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pend_i(pend), .pin_o(pin), .nmi_o(nmi)
    );

    typedef struct {
        bit          is_read;
        logic [31:0] exp_rd;
        logic [OW-1:0] exp_pin;
        logic [NC-1:0] exp_nmi;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] route_m[NS];
    logic [NC-1:0] tgt_m[NS];

    function automatic void model(input logic [NS-1:0] p, output logic [OW-1:0] ep,
                                  output logic [NC-1:0] en);
        ep = '0;
        en = '0;
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < NC; c++) begin
                if (p[s] && tgt_m[s][c]) begin
                    if (route_m[s][31]) ep[c*64 + int'(route_m[s][5:0])] = 1'b1;
                    if (route_m[s][30]) en[c] = 1'b1;
                end
            end
        end
    endfunction

    function automatic void push_out(input string tag);
        item_t it;
        it.is_read = 1'b0;
        it.exp_rd  = '0;
        model(pend, it.exp_pin, it.exp_nmi);
        it.tag = tag;
        sb.push_back(it);
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.is_read) begin
                if (rdata !== it.exp_rd) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp_rd);
                end
            end else if (pin !== it.exp_pin || nmi !== it.exp_nmi) begin
                n_fail++;
                $display("FAIL %s: pin actual %h expected %h, nmi actual %b expected %b",
                         it.tag, pin, it.exp_pin, nmi, it.exp_nmi);
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        push_out("R10 old routing holds at write edge");
        if (a[1:0] == 2'b00 && a[9] == 1'b0 && int'(a[7:2]) < NS) begin
            if (a[8]) tgt_m[a[7:2]] = d[NC-1:0];
            else      route_m[a[7:2]] = d & 32'hC000_003F;
        end
        @(negedge clk);
        valid = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        valid = 1'b1; wr = 1'b0; addr = a;
        @(posedge clk);
        #1;
        it.is_read = 1'b1; it.exp_rd = e; it.exp_pin = '0; it.exp_nmi = '0; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic drive(input logic [NS-1:0] p, input string tag);
        @(negedge clk);
        pend = p;
        @(posedge clk);
        #1;
        push_out(tag);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            route_m[s] = '0;
            tgt_m[s] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        push_out("R1 reset outputs");
        begin
            item_t it;
            it.is_read = 1'b1; it.exp_rd = '0; it.exp_pin = '0; it.exp_nmi = '0;
            it.tag = "R1 reset rdata";
            sb.push_back(it);
        end
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(10'h000, 32'h0, "R1 route word 0 after reset");
        bus_rd(10'h11C, 32'h0, "R1 target word 7 after reset");

        // R2 / R3 readback masking
        bus_wr(10'h004, 32'hFFFF_FFFF);
        bus_rd(10'h004, 32'hC000_003F, "R2 route reserved bits read zero");
        bus_wr(10'h104, 32'hFFFF_FFF5);
        bus_rd(10'h104, 32'h0000_0005, "R3 target keeps NUM_CPU bits");
        // R4 out of range
        bus_wr(10'h020, 32'h8000_0001);
        bus_rd(10'h020, 32'h0, "R4 unmapped read zero");
        bus_wr(10'h204, 32'h0000_0000);
        bus_rd(10'h004, 32'hC000_003F, "R4 unmapped write ignored");

        // R5 single source pin delivery
        bus_wr(10'h000, 32'h8000_0011);
        bus_wr(10'h100, 32'h0000_0002);
        drive(8'h01, "R5 source 0 to cpu1 pin 17");
        drive(8'h00, "R5 released");
        // R6 OR of sources on same pin
        bus_wr(10'h008, 32'h8000_0011);
        bus_wr(10'h108, 32'h0000_0002);
        drive(8'h05, "R6 two sources one pin");
        drive(8'h04, "R6 one of two still holds pin");
        // R7 NMI only, and both
        bus_wr(10'h00C, 32'h4000_0003);
        bus_wr(10'h10C, 32'h0000_0008);
        drive(8'h08, "R7 nmi only on cpu3");
        bus_wr(10'h00C, 32'hC000_0003);
        drive(8'h08, "R7 pin and nmi together");
        // R8 no enables
        bus_wr(10'h010, 32'h0000_002A);
        bus_wr(10'h110, 32'h0000_000F);
        drive(8'h10, "R8 disabled source quiet");
        // R9 zero target and multi target
        bus_wr(10'h014, 32'hC000_003F);
        drive(8'h20, "R9 zero target quiet");
        bus_wr(10'h114, 32'h0000_000D);
        drive(8'h20, "R9 multi-target fanout");
        // R10 change while pending
        bus_wr(10'h014, 32'h8000_0000);
        drive(8'h20, "R10 new routing after one cycle");
        // R5 all sources at once
        drive(8'hFF, "R5 all sources pending");
        drive(8'h00, "R5 all released");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule